// File: doc/BRIEF.md
# Receive Line AIS Alarm Aggregator

This block decides when the receive 140 Mbit/s line must carry an alarm indication signal (AIS), and drives a matching AIS status output. It merges a software force bit with a set of alarm sources. Each source is gated by its own enable or by the pointer-mode strap, and a global enable gates them all. The alarm detectors and the all-ones insertion sit outside the block. It only produces the request.

Upstream AIS arrives in one of two ways. It can come out of band on two external pins. It can also come in band, carried in an overhead byte, where a majority vote decides it. A control bit picks between the two. A microprocessor writes every control bit through a single write-only register. The same register also selects the line clock edge on which the byte- or nibble-wide receive data leaves the block.

A three-state machine holds the request. The states are `AIS_CLEAR` (no AIS), `AIS_ALARM` (AIS requested by a gated alarm) and `AIS_FORCED` (AIS requested by software). On every clock it moves to `AIS_FORCED` when the force bit is 1. Otherwise it moves to `AIS_ALARM` when a gated alarm is present, and otherwise to `AIS_CLEAR`. The named transitions are:

- clear-to-alarm
- clear-to-forced
- alarm-to-forced
- alarm-to-clear
- forced-to-alarm
- forced-to-clear

Top module: `rxais_alarm_merge`

## Requirements
- R1: After reset, every control bit is 0, `line_ais_req` and `ais_ind` are 0, and receive data leaves on the falling clock edge.
- R2: Force bit (control bit 0) at 1 requests AIS regardless of every alarm and of the global enable.
- R3: Global enable (control bit 1) at 0 blocks every alarm source, so only the force bit can request AIS.
- R4: A low level on `exais_n` requests AIS when the global enable is 1.
- R5: Pin select (control bit 2) at 1 makes `ext_stat` OR `ext_path_ais` the upstream AIS source and ignores the in-band vote. At 0, the two pins are ignored and the in-band vote is used.
- R6: On a cycle with `oh_byte_vld` high, the in-band flag becomes 1 when at least 5 of the 8 bits of `oh_byte` are 1, and 0 otherwise. Without the strobe, the flag holds.
- R7: `dbus_ref_loss` counts only while `ptr_mode` is 0. `pointer_loss` and `path_ais` count only while `ptr_mode` is 1.
- R8: `label_mismatch` and `unequipped` count only while label enable (control bit 3) is 1.
- R9: `trace_lock_loss` counts only while lock enable (bit 4) is 1. `trace_mismatch` counts only while mismatch enable (bit 5) is 1.
- R10: `dbus_clk_loss` counts only while clock-loss ignore (bit 6) is 0.
- R11: `frame_loss` counts only while frame-loss enable (bit 7) is 1.
- R12: Edge select (bit 8) at 0 launches `rx_data_in` on the falling clock edge. At 1, it launches on the rising edge.
- R13: `line_ais_req` is registered, changing on the clock edge after the sources change, and `ais_ind` always equals it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr_en | input | 1 | Control register write strobe |
| reg_wdata | input | 9 | Control register write value |
| ptr_mode | input | 1 | Pointer-mode strap |
| exais_n | input | 1 | External AIS request, active low |
| ext_stat | input | 1 | Out-of-band upstream AIS pin A |
| ext_path_ais | input | 1 | Out-of-band upstream AIS pin B |
| oh_byte | input | 8 | In-band overhead byte |
| oh_byte_vld | input | 1 | Overhead byte valid, once per frame |
| dbus_ref_loss | input | 1 | Drop bus loss of path reference byte |
| dbus_clk_loss | input | 1 | Drop bus loss of clock |
| label_mismatch | input | 1 | Signal label mismatch |
| unequipped | input | 1 | Unequipped status |
| trace_lock_loss | input | 1 | Trace loss of lock |
| trace_mismatch | input | 1 | Trace message mismatch |
| pointer_loss | input | 1 | Loss of pointer |
| path_ais | input | 1 | Path AIS |
| frame_loss | input | 1 | Receive loss of frame alignment |
| rx_data_in | input | 8 | Receive line data to launch |
| rx_data_out | output | 8 | Receive line data, launched on the selected edge |
| line_ais_req | output | 1 | Registered line AIS request |
| ais_ind | output | 1 | AIS status indication |

## Verification
A level change on any alarm input shows up on `line_ais_req` and `ais_ind` one rising edge later. A control write, or an overhead byte strobe, is captured on one edge and shows up on the request one edge after that. Launched data appears at the falling edge of the same cycle when bit 8 is 0, and at the next rising edge when it is 1. The bench drives inputs 2 ns after a rising edge and samples 7 ns after it, past the falling edge. A behavioural model in the bench advances at each rising edge on the inputs the design saw, and predicts every output in every cycle.

// File: rtl/rxais_pkg.sv
package rxais_pkg;

    typedef enum logic [1:0] {
        AIS_CLEAR  = 2'b00,
        AIS_ALARM  = 2'b01,
        AIS_FORCED = 2'b10
    } ais_state_t;

    // Field order sets the write-data bit positions: force_ais is bit 0, edge_rise is bit 8.
    typedef struct packed {
        logic edge_rise;
        logic lof_en;
        logic clkloss_ignore;
        logic trc_mis_en;
        logic trc_lock_en;
        logic lbl_en;
        logic ext_sel;
        logic glob_en;
        logic force_ais;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/rxais_ctrl_regs.sv
module rxais_ctrl_regs
    import rxais_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wdata,
    output ctrl_t             ctrl_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_en) begin
            ctrl_q <= ctrl_t'(wdata);
        end
    end

endmodule

// File: rtl/rxais_inband_vote.sv
module rxais_inband_vote #(
    parameter int BYTE_W     = 8,
    parameter int MAJ_THRESH = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic              byte_vld,
    output logic              inband_ais
);

    localparam int CNT_W = $clog2(BYTE_W + 1);

    logic [CNT_W-1:0] ones_cnt;

    always_comb begin
        ones_cnt = '0;
        for (int i = 0; i < BYTE_W; i++) begin
            ones_cnt = ones_cnt + CNT_W'(byte_in[i]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            inband_ais <= 1'b0;
        end else if (byte_vld) begin
            inband_ais <= (ones_cnt >= CNT_W'(MAJ_THRESH));
        end
    end

endmodule

// File: rtl/rxais_source_gate.sv
module rxais_source_gate
    import rxais_pkg::*;
(
    input  ctrl_t ctrl,
    input  logic  ptr_mode,
    input  logic  exais_n,
    input  logic  ext_stat,
    input  logic  ext_path_ais,
    input  logic  inband_ais,
    input  logic  dbus_ref_loss,
    input  logic  dbus_clk_loss,
    input  logic  label_mismatch,
    input  logic  unequipped,
    input  logic  trace_lock_loss,
    input  logic  trace_mismatch,
    input  logic  pointer_loss,
    input  logic  path_ais,
    input  logic  frame_loss,
    output logic  alarm_req
);

    logic upstream;
    logic ptr_side;
    logic bus_side;
    logic path_side;
    logic any_src;

    always_comb begin
        upstream  = ctrl.ext_sel ? (ext_stat | ext_path_ais) : inband_ais;
        ptr_side  = ptr_mode & (pointer_loss | path_ais);
        bus_side  = (~ptr_mode & dbus_ref_loss) | (~ctrl.clkloss_ignore & dbus_clk_loss);
        path_side = (ctrl.lbl_en & (label_mismatch | unequipped))
                  | (ctrl.trc_lock_en & trace_lock_loss)
                  | (ctrl.trc_mis_en & trace_mismatch)
                  | (ctrl.lof_en & frame_loss);
        any_src   = ~exais_n | upstream | ptr_side | bus_side | path_side;
        alarm_req = ctrl.glob_en & any_src;
    end

endmodule

// File: rtl/rxais_line_launch.sv
module rxais_line_launch #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              edge_rise,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] data_out
);

    logic [DATA_W-1:0] rise_q;
    logic [DATA_W-1:0] fall_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rise_q <= '0;
        end else begin
            rise_q <= data_in;
        end
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fall_q <= '0;
        end else begin
            fall_q <= data_in;
        end
    end

    assign data_out = edge_rise ? rise_q : fall_q;

endmodule

// File: rtl/rxais_alarm_merge.sv
module rxais_alarm_merge
    import rxais_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int BYTE_W     = 8,
    parameter int MAJ_THRESH = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [CTRL_W-1:0] reg_wdata,
    input  logic              ptr_mode,
    input  logic              exais_n,
    input  logic              ext_stat,
    input  logic              ext_path_ais,
    input  logic [BYTE_W-1:0] oh_byte,
    input  logic              oh_byte_vld,
    input  logic              dbus_ref_loss,
    input  logic              dbus_clk_loss,
    input  logic              label_mismatch,
    input  logic              unequipped,
    input  logic              trace_lock_loss,
    input  logic              trace_mismatch,
    input  logic              pointer_loss,
    input  logic              path_ais,
    input  logic              frame_loss,
    input  logic [DATA_W-1:0] rx_data_in,
    output logic [DATA_W-1:0] rx_data_out,
    output logic              line_ais_req,
    output logic              ais_ind
);

    ctrl_t      ctrl_q;
    logic       inband_ais;
    logic       alarm_req;
    ais_state_t state_q;
    ais_state_t state_d;

    rxais_ctrl_regs u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (reg_wr_en),
        .wdata  (reg_wdata),
        .ctrl_q (ctrl_q)
    );

    rxais_inband_vote #(
        .BYTE_W     (BYTE_W),
        .MAJ_THRESH (MAJ_THRESH)
    ) u_vote (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_in    (oh_byte),
        .byte_vld   (oh_byte_vld),
        .inband_ais (inband_ais)
    );

    rxais_source_gate u_gate (
        .ctrl            (ctrl_q),
        .ptr_mode        (ptr_mode),
        .exais_n         (exais_n),
        .ext_stat        (ext_stat),
        .ext_path_ais    (ext_path_ais),
        .inband_ais      (inband_ais),
        .dbus_ref_loss   (dbus_ref_loss),
        .dbus_clk_loss   (dbus_clk_loss),
        .label_mismatch  (label_mismatch),
        .unequipped      (unequipped),
        .trace_lock_loss (trace_lock_loss),
        .trace_mismatch  (trace_mismatch),
        .pointer_loss    (pointer_loss),
        .path_ais        (path_ais),
        .frame_loss      (frame_loss),
        .alarm_req       (alarm_req)
    );

    rxais_line_launch #(
        .DATA_W (DATA_W)
    ) u_launch (
        .clk       (clk),
        .rst_n     (rst_n),
        .edge_rise (ctrl_q.edge_rise),
        .data_in   (rx_data_in),
        .data_out  (rx_data_out)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= AIS_CLEAR;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic: software force outranks gated alarms
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            AIS_CLEAR: begin
                if (ctrl_q.force_ais)  state_d = AIS_FORCED;   // clear-to-forced
                else if (alarm_req)    state_d = AIS_ALARM;    // clear-to-alarm
            end
            AIS_ALARM: begin
                if (ctrl_q.force_ais)  state_d = AIS_FORCED;   // alarm-to-forced
                else if (!alarm_req)   state_d = AIS_CLEAR;    // alarm-to-clear
            end
            AIS_FORCED: begin
                if (!ctrl_q.force_ais) begin
                    if (alarm_req)     state_d = AIS_ALARM;    // forced-to-alarm
                    else               state_d = AIS_CLEAR;    // forced-to-clear
                end
            end
            default:                   state_d = AIS_CLEAR;
        endcase
    end

    // Outputs decoded from the state register only
    always_comb begin
        line_ais_req = (state_q != AIS_CLEAR);
        ais_ind      = line_ais_req;
    end

endmodule

// File: rtl/rxais_alarm_merge_chk.sv
module rxais_alarm_merge_chk #(
    parameter int BYTE_W     = 8,
    parameter int MAJ_THRESH = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              force_on,
    input logic              glob_on,
    input logic              exais_n,
    input logic [BYTE_W-1:0] oh_byte,
    input logic              oh_byte_vld,
    input logic              inband_ais,
    input logic              alarm_req,
    input logic              line_ais_req
);

    assert_force_R2: assert property (@(posedge clk) disable iff (!rst_n)
        force_on |=> line_ais_req);

    assert_global_block_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!glob_on && !force_on) |=> !line_ais_req);

    assert_exais_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (glob_on && !exais_n) |=> line_ais_req);

    assert_vote_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (oh_byte_vld && ($countones(oh_byte) >= MAJ_THRESH)) |=> inband_ais);

    assert_vote_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !oh_byte_vld |=> $stable(inband_ais));

    assert_rise_cause_R13: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(line_ais_req) |-> $past(force_on || alarm_req));

endmodule

bind rxais_alarm_merge rxais_alarm_merge_chk #(
    .BYTE_W     (BYTE_W),
    .MAJ_THRESH (MAJ_THRESH)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .force_on     (ctrl_q.force_ais),
    .glob_on      (ctrl_q.glob_en),
    .exais_n      (exais_n),
    .oh_byte      (oh_byte),
    .oh_byte_vld  (oh_byte_vld),
    .inband_ais   (inband_ais),
    .alarm_req    (alarm_req),
    .line_ais_req (line_ais_req)
);

// File: tb/rxais_alarm_merge_tb_top.sv
module rxais_alarm_merge_tb_top;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr_en = 1'b0;
    logic [8:0] reg_wdata = '0;
    logic       ptr_mode = 1'b0;
    logic       exais_n = 1'b1;
    logic       ext_stat = 1'b0;
    logic       ext_path_ais = 1'b0;
    logic [7:0] oh_byte = '0;
    logic       oh_byte_vld = 1'b0;
    logic       dbus_ref_loss = 1'b0;
    logic       dbus_clk_loss = 1'b0;
    logic       label_mismatch = 1'b0;
    logic       unequipped = 1'b0;
    logic       trace_lock_loss = 1'b0;
    logic       trace_mismatch = 1'b0;
    logic       pointer_loss = 1'b0;
    logic       path_ais = 1'b0;
    logic       frame_loss = 1'b0;
    logic [7:0] rx_data_in = '0;
    logic [7:0] rx_data_out;
    logic       line_ais_req;
    logic       ais_ind;

    int    n_tests = 0;
    int    n_fail  = 0;
    bit    done    = 1'b0;
    string cur_req = "R1";

    // Behavioural model state
    int         m_state  = 0;   // 0 none, 1 alarm, 2 forced
    logic [8:0] m_ctrl   = '0;
    bit         m_inband = 1'b0;
    logic [7:0] m_rise   = '0;
    logic [7:0] m_fall   = '0;
    int         cyc      = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rxais_alarm_merge dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
        .ptr_mode(ptr_mode), .exais_n(exais_n), .ext_stat(ext_stat),
        .ext_path_ais(ext_path_ais), .oh_byte(oh_byte), .oh_byte_vld(oh_byte_vld),
        .dbus_ref_loss(dbus_ref_loss), .dbus_clk_loss(dbus_clk_loss),
        .label_mismatch(label_mismatch), .unequipped(unequipped),
        .trace_lock_loss(trace_lock_loss), .trace_mismatch(trace_mismatch),
        .pointer_loss(pointer_loss), .path_ais(path_ais), .frame_loss(frame_loss),
        .rx_data_in(rx_data_in), .rx_data_out(rx_data_out),
        .line_ais_req(line_ais_req), .ais_ind(ais_ind)
    );

    task automatic chk(string req, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s at cycle %0d: actual %0h expected %0h", req, cyc, act, exp);
        end
    endtask

    function automatic bit model_alarm();
        bit up;
        bit any;
        int ones;
        ones = 0;
        up = m_ctrl[2] ? (ext_stat || ext_path_ais) : m_inband;
        any = !exais_n || up;
        if (!ptr_mode && dbus_ref_loss) any = 1;
        if (ptr_mode && (pointer_loss || path_ais)) any = 1;
        if (!m_ctrl[6] && dbus_clk_loss) any = 1;
        if (m_ctrl[3] && (label_mismatch || unequipped)) any = 1;
        if (m_ctrl[4] && trace_lock_loss) any = 1;
        if (m_ctrl[5] && trace_mismatch) any = 1;
        if (m_ctrl[7] && frame_loss) any = 1;
        return m_ctrl[1] && any;
    endfunction

    task automatic model_edge();
        int ones;
        if (!rst_n) return;
        if (m_ctrl[0])          m_state = 2;
        else if (model_alarm()) m_state = 1;
        else                    m_state = 0;
        if (reg_wr_en) m_ctrl = reg_wdata;
        if (oh_byte_vld) begin
            ones = 0;
            for (int b = 0; b < 8; b++) ones += oh_byte[b];
            m_inband = (ones >= 5);
        end
        m_rise = rx_data_in;
    endtask

    task automatic tick(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            model_edge();
            cyc++;
            #2;
            rx_data_in = 8'(cyc * 37 + 5);
            if (rst_n) m_fall = rx_data_in;
            #5;
            chk(cur_req, line_ais_req, (m_state != 0));
            chk("R13", ais_ind, line_ais_req);
            chk("R12", rx_data_out, m_ctrl[8] ? m_rise : m_fall);
        end
    endtask

    task automatic wr(logic [8:0] v);
        reg_wr_en = 1'b1;
        reg_wdata = v;
        tick(1);
        reg_wr_en = 1'b0;
    endtask

    task automatic vote(logic [7:0] b);
        oh_byte = b;
        oh_byte_vld = 1'b1;
        tick(1);
        oh_byte_vld = 1'b0;
        oh_byte = 8'h00;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        // R1: reset state
        cur_req = "R1";
        tick(3);
        rst_n = 1'b1;
        tick(2);
        chk("R1", line_ais_req, 0);
        chk("R1", ais_ind, 0);

        // R2: force beats a disabled global enable
        cur_req = "R2";
        wr(9'h001); tick(3);
        chk("R2", line_ais_req, 1);
        wr(9'h000); tick(2);

        // R3: global enable off blocks everything
        cur_req = "R3";
        exais_n = 0; ext_stat = 1; dbus_ref_loss = 1; dbus_clk_loss = 1;
        label_mismatch = 1; trace_lock_loss = 1; frame_loss = 1;
        wr(9'h0FC); tick(3);
        chk("R3", line_ais_req, 0);
        exais_n = 1; ext_stat = 0; dbus_ref_loss = 0; dbus_clk_loss = 0;
        label_mismatch = 0; trace_lock_loss = 0; frame_loss = 0;
        wr(9'h002); tick(2);

        // R4: active-low external request
        cur_req = "R4";
        exais_n = 0; tick(2);
        chk("R4", line_ais_req, 1);
        exais_n = 1; tick(2);

        // R5: pin select
        cur_req = "R5";
        ext_stat = 1; tick(2);
        wr(9'h006); tick(2);
        ext_stat = 0; ext_path_ais = 1; tick(2);
        ext_path_ais = 0; vote(8'hFF); tick(2);
        chk("R5", line_ais_req, 0);
        wr(9'h002); tick(2);
        chk("R5", line_ais_req, 1);
        vote(8'h00); tick(2);

        // R6: majority vote, strobe-only updates
        cur_req = "R6";
        vote(8'h1F); tick(2);
        chk("R6", line_ais_req, 1);
        oh_byte = 8'h00; tick(3); oh_byte = 8'h00;
        vote(8'h0F); tick(2);
        chk("R6", line_ais_req, 0);
        vote(8'hB5); tick(2);
        vote(8'h81); tick(2);

        // R7: pointer-mode strap
        cur_req = "R7";
        dbus_ref_loss = 1; tick(2);
        dbus_ref_loss = 0; pointer_loss = 1; path_ais = 1; tick(2);
        ptr_mode = 1; tick(2);
        pointer_loss = 0; tick(2);
        path_ais = 0; dbus_ref_loss = 1; tick(2);
        chk("R7", line_ais_req, 0);
        dbus_ref_loss = 0; ptr_mode = 0; tick(1);

        // R8: label enable
        cur_req = "R8";
        label_mismatch = 1; tick(2);
        wr(9'h00A); tick(2);
        label_mismatch = 0; unequipped = 1; tick(2);
        unequipped = 0; wr(9'h002); tick(1);

        // R9: trace enables
        cur_req = "R9";
        trace_lock_loss = 1; tick(2);
        wr(9'h012); tick(2);
        trace_lock_loss = 0; trace_mismatch = 1; tick(2);
        wr(9'h022); tick(2);
        trace_mismatch = 0; tick(2);

        // R10: clock-loss ignore bit
        cur_req = "R10";
        dbus_clk_loss = 1; tick(2);
        wr(9'h042); tick(2);
        chk("R10", line_ais_req, 0);
        dbus_clk_loss = 0; wr(9'h002); tick(1);

        // R11: frame-loss enable
        cur_req = "R11";
        frame_loss = 1; tick(2);
        wr(9'h082); tick(2);
        chk("R11", line_ais_req, 1);
        frame_loss = 0; tick(2);

        // R12: launch edge select; force also exercised with alarms present (R2)
        cur_req = "R12";
        wr(9'h100); tick(4);
        wr(9'h003); exais_n = 0; tick(2);
        wr(9'h002); tick(2);
        exais_n = 1; wr(9'h000); tick(3);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule